// File: doc/BRIEF.md
# Segmented Logical-to-Physical Address Translator

This block turns a two-part logical address, a segment index plus a byte offset, into a physical address. It holds a small table of segments in internal registers, each with a starting physical address (base) and a length (limit). A count register says how many table entries are in use. Each request goes through two checks in a fixed order. First the segment index is checked against the count. Then the offset is checked against that segment's limit. Only when both checks pass is the base added to the offset. A request that fails a check returns a trap with a cause code and no address.

Requests and responses each use a valid/ready handshake. An accepted request gives its response one clock later. The response is held while the consumer stalls. Two write ports load the table: one for an entry's base and limit, one for the count. A write takes effect at the clock edge that ends its cycle, so a request in that same cycle still sees the old contents.

Top module: `segXlate`

## Requirements
- R1: After reset, `rspValid` is 0, `reqReady` is 1 and the active-segment count is 0, so every request traps with cause 1 until the count is written.
- R2: An accepted request whose segment index is greater than or equal to the active-segment count returns `rspCause` = 1 (illegal segment), `rspTrap` = 1 and `rspAddr` = 0.
- R3: An accepted request with a legal segment whose offset is greater than or equal to that segment's limit returns `rspCause` = 2 (offset out of range), `rspTrap` = 1 and `rspAddr` = 0. The highest offset that passes is limit-1.
- R4: The segment check comes before the offset check. A request that fails both returns cause 1. `rspCause` never has both bits set.
- R5: A request that passes both checks returns `rspCause` = 0, `rspTrap` = 0 and `rspAddr` = (base + offset) modulo 2^PA_BITS.
- R6: A request accepted at a clock edge (`reqValid` and `reqReady` both high) gives `rspValid` = 1 right after that edge. With no new request and `rspReady` high, `rspValid` falls after the next edge.
- R7: While `rspValid` is high and `rspReady` is low, `reqReady` is low and the response (`rspValid`, `rspAddr`, `rspCause`) stays unchanged.
- R8: A write to a table entry or to the count takes effect at the edge that ends its cycle. A request accepted at that same edge is checked against the old values, and the next request sees the new ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Request can be taken this cycle |
| reqSeg | input | SEG_BITS | Segment index of the logical address |
| reqOff | input | OFF_BITS | Byte offset of the logical address |
| rspValid | output | 1 | Response present |
| rspReady | input | 1 | Consumer takes the response |
| rspAddr | output | PA_BITS | Physical address (0 on a trap) |
| rspTrap | output | 1 | The response is a trap |
| rspCause | output | 2 | 0 none, 1 illegal segment, 2 offset out of range |
| tblWe | input | 1 | Write one table entry |
| tblIdx | input | SEG_BITS | Entry to write |
| tblBase | input | PA_BITS | Base to store |
| tblLimit | input | OFF_BITS+1 | Segment length to store |
| lenWe | input | 1 | Write the active-segment count |
| lenVal | input | SEG_BITS+1 | New active-segment count (0 to 2^SEG_BITS) |

## Verification
The assertions assume that the request inputs are stable and meaningful whenever `reqValid` is high. They also assume that `rspReady` only matters while a response is pending, and that the count written never exceeds the table size. The bench drives every input half a cycle away from the active edge. It keeps the written count within 0 to 8, and it holds a request steady while the block is stalled. This means the stall checks only ever see a properly held request. The address sum is checked for wraparound in its own case. The offset ceiling is checked at limit-1 and at limit.

// File: rtl/seg_pkg.sv
package seg_pkg;
  typedef enum logic [1:0] {
    CAUSE_NONE = 2'd0,
    CAUSE_SEG  = 2'd1,
    CAUSE_OFF  = 2'd2
  } trapCause_e;

  typedef struct packed {
    logic loadRsp;
    logic wrTbl;
    logic wrLen;
  } segStrobe_t;
endpackage

// File: rtl/segCtrl.sv
module segCtrl
  import seg_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       rspReady,
  input  logic       tblWe,
  input  logic       lenWe,
  output logic       reqReady,
  output logic       rspValid,
  output segStrobe_t st
);
  logic validQ;
  logic accept;

  assign reqReady = !validQ || rspReady;
  assign accept   = reqValid && reqReady;

  always_ff @(posedge clk) begin
    if (!rstN)       validQ <= 1'b0;
    else if (accept) validQ <= 1'b1;
    else if (rspReady) validQ <= 1'b0;
  end

  always_comb begin
    st.loadRsp = accept;
    st.wrTbl   = tblWe;
    st.wrLen   = lenWe;
  end

  assign rspValid = validQ;
endmodule

// File: rtl/segData.sv
module segData
  import seg_pkg::*;
#(
  parameter int SEG_BITS = 3,
  parameter int OFF_BITS = 12,
  parameter int PA_BITS  = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  segStrobe_t          st,
  input  logic [SEG_BITS-1:0] reqSeg,
  input  logic [OFF_BITS-1:0] reqOff,
  input  logic [SEG_BITS-1:0] tblIdx,
  input  logic [PA_BITS-1:0]  tblBase,
  input  logic [OFF_BITS:0]   tblLimit,
  input  logic [SEG_BITS:0]   lenVal,
  output logic [PA_BITS-1:0]  rspAddr,
  output logic [1:0]          rspCause,
  output logic [SEG_BITS:0]   lenQ
);
  localparam int NSEG = 1 << SEG_BITS;

  logic [PA_BITS-1:0] baseQ [NSEG];
  logic [OFF_BITS:0]  limQ  [NSEG];

  for (genvar i = 0; i < NSEG; i++) begin : g_entry
    always_ff @(posedge clk) begin
      if (!rstN) begin
        baseQ[i] <= '0;
        limQ[i]  <= '0;
      end else if (st.wrTbl && tblIdx == SEG_BITS'(i)) begin
        baseQ[i] <= tblBase;
        limQ[i]  <= tblLimit;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)         lenQ <= '0;
    else if (st.wrLen) lenQ <= lenVal;
  end

  // two ordered bound checks, then the add
  logic               segOk, offOk;
  logic [PA_BITS-1:0] sum;
  trapCause_e         cause;

  always_comb begin
    segOk = {1'b0, reqSeg} < lenQ;
    offOk = {1'b0, reqOff} < limQ[reqSeg];
    sum   = baseQ[reqSeg] + PA_BITS'(reqOff);
    if (!segOk)      cause = CAUSE_SEG;
    else if (!offOk) cause = CAUSE_OFF;
    else             cause = CAUSE_NONE;
  end

  logic [PA_BITS-1:0] addrQ;
  trapCause_e         causeQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ  <= '0;
      causeQ <= CAUSE_NONE;
    end else if (st.loadRsp) begin
      addrQ  <= (cause == CAUSE_NONE) ? sum : '0;
      causeQ <= cause;
    end
  end

  assign rspAddr  = addrQ;
  assign rspCause = causeQ;
endmodule

// File: rtl/segXlate.sv
module segXlate
  import seg_pkg::*;
#(
  parameter int SEG_BITS = 3,
  parameter int OFF_BITS = 12,
  parameter int PA_BITS  = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                reqValid,
  output logic                reqReady,
  input  logic [SEG_BITS-1:0] reqSeg,
  input  logic [OFF_BITS-1:0] reqOff,
  output logic                rspValid,
  input  logic                rspReady,
  output logic [PA_BITS-1:0]  rspAddr,
  output logic                rspTrap,
  output logic [1:0]          rspCause,
  input  logic                tblWe,
  input  logic [SEG_BITS-1:0] tblIdx,
  input  logic [PA_BITS-1:0]  tblBase,
  input  logic [OFF_BITS:0]   tblLimit,
  input  logic                lenWe,
  input  logic [SEG_BITS:0]   lenVal
);
  segStrobe_t          st;
  logic [SEG_BITS:0]   lenQ;

  segCtrl u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .rspReady(rspReady),
    .tblWe(tblWe), .lenWe(lenWe), .reqReady(reqReady), .rspValid(rspValid),
    .st(st)
  );

  segData #(.SEG_BITS(SEG_BITS), .OFF_BITS(OFF_BITS), .PA_BITS(PA_BITS)) u_data (
    .clk(clk), .rstN(rstN), .st(st), .reqSeg(reqSeg), .reqOff(reqOff),
    .tblIdx(tblIdx), .tblBase(tblBase), .tblLimit(tblLimit), .lenVal(lenVal),
    .rspAddr(rspAddr), .rspCause(rspCause), .lenQ(lenQ)
  );

  assign rspTrap = (rspCause != 2'd0);
endmodule

// File: rtl/segChk.sv
module segChk #(
  parameter int SEG_BITS = 3,
  parameter int PA_BITS  = 16
) (
  input logic                clk,
  input logic                rstN,
  input logic                reqValid,
  input logic                reqReady,
  input logic [SEG_BITS-1:0] reqSeg,
  input logic                rspValid,
  input logic                rspReady,
  input logic [PA_BITS-1:0]  rspAddr,
  input logic [1:0]          rspCause,
  input logic [SEG_BITS:0]   lenQ
);
  // R6
  accept_to_rsp_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && reqReady |=> rspValid);

  // R7
  hold_rsp_chk: assert property (@(posedge clk) disable iff (!rstN)
    rspValid && !rspReady |=> rspValid && $stable(rspAddr) && $stable(rspCause));

  // R7
  stall_ready_chk: assert property (@(posedge clk) disable iff (!rstN)
    rspValid && !rspReady |-> !reqReady);

  // R2
  seg_trap_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && reqReady && ({1'b0, reqSeg} >= lenQ) |=> rspCause == 2'd1);

  // R3
  trap_zero_addr_chk: assert property (@(posedge clk) disable iff (!rstN)
    rspValid && rspCause != 2'd0 |-> rspAddr == '0);

  // R4
  cause_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> $onehot0(rspCause));
endmodule

bind segXlate segChk #(.SEG_BITS(SEG_BITS), .PA_BITS(PA_BITS)) u_chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
  .reqSeg(reqSeg), .rspValid(rspValid), .rspReady(rspReady),
  .rspAddr(rspAddr), .rspCause(rspCause), .lenQ(lenQ)
);

// File: tb/sim_segXlate.sv
`timescale 1ns/1ps
module sim_segXlate;
  localparam int SB = 3, OB = 12, PB = 16, NS = 8;

  logic clk = 0, rstN = 0;
  logic reqValid = 0, rspReady = 1, tblWe = 0, lenWe = 0;
  logic [SB-1:0] reqSeg = '0, tblIdx = '0;
  logic [OB-1:0] reqOff = '0;
  logic [PB-1:0] tblBase = '0;
  logic [OB:0]   tblLimit = '0;
  logic [SB:0]   lenVal = '0;
  logic reqReady, rspValid, rspTrap;
  logic [PB-1:0] rspAddr;
  logic [1:0] rspCause;

  segXlate #(.SEG_BITS(SB), .OFF_BITS(OB), .PA_BITS(PB)) u0 (.*);

  always #10 clk = ~clk;

  int errors = 0, checks = 0;
  bit done = 0;
  int mBase[NS], mLim[NS], mLen;
  int mValid, mAddr, mCause;

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // one clock: model update, then compare outputs half a cycle later
  task automatic step(string tag);
    int mReady, acc, c;
    #1;
    mReady = (mValid == 0 || rspReady) ? 1 : 0;
    chk(tag, "reqReady", int'(reqReady), mReady);
    acc = (reqValid && mReady) ? 1 : 0;
    if (acc) begin
      if (int'(reqSeg) >= mLen) c = 1;
      else if (int'(reqOff) >= mLim[reqSeg]) c = 2;
      else c = 0;
      mCause = c;
      mAddr  = (c == 0) ? (mBase[reqSeg] + int'(reqOff)) % 65536 : 0;
      mValid = 1;
    end else if (rspReady) mValid = 0;
    if (tblWe) begin mBase[tblIdx] = int'(tblBase); mLim[tblIdx] = int'(tblLimit); end
    if (lenWe) mLen = int'(lenVal);
    @(negedge clk);
    chk(tag, "rspValid", int'(rspValid), mValid);
    if (mValid) begin
      chk(tag, "rspCause", int'(rspCause), mCause);
      chk(tag, "rspTrap", int'(rspTrap), mCause != 0);
      chk(tag, "rspAddr", int'(rspAddr), mAddr);
    end
    tblWe = 0; lenWe = 0;
  endtask

  task automatic req(int s, int o);
    reqValid = 1; reqSeg = SB'(s); reqOff = OB'(o);
  endtask

  task automatic wrEnt(int i, int b, int l);
    tblWe = 1; tblIdx = SB'(i); tblBase = PB'(b); tblLimit = (OB+1)'(l);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NS; i++) begin mBase[i] = 0; mLim[i] = 0; end
    mLen = 0; mValid = 0; mAddr = 0; mCause = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
    #1;
    chk("R1", "rspValid", int'(rspValid), 0);
    chk("R1", "reqReady", int'(reqReady), 1);
    req(0, 0); step("R1");
    reqValid = 0; step("R6");
    // load table
    wrEnt(2, 4300, 400);  step("R8");
    wrEnt(3, 3200, 1100); step("R8");
    wrEnt(0, 1400, 1000); step("R8");
    wrEnt(4, 16'hFFF8, 10); step("R8");
    // count write with a request in the same cycle: old count 0
    lenWe = 1; lenVal = 4'd5; req(2, 53); step("R8");
    req(2, 53);   step("R5");
    req(3, 852);  step("R5");
    req(0, 1222); step("R3");
    req(0, 999);  step("R3");
    req(0, 1000); step("R3");
    req(4, 9);    step("R5");
    req(4, 10);   step("R3");
    req(5, 0);    step("R2");
    req(7, 4095); step("R4");
    req(1, 0);    step("R3");
    reqValid = 0; step("R6");
    step("R6");
    // backpressure
    req(3, 0); step("R7");
    rspReady = 0; req(3, 1); step("R7");
    step("R7"); step("R7");
    rspReady = 1; step("R7");
    reqValid = 0; step("R7");
    // entry rewrite alongside a request: old entry used
    wrEnt(2, 100, 400); req(2, 53); step("R8");
    req(2, 53); step("R8");
    // shrink the count: segment 4 turns illegal
    lenWe = 1; lenVal = 4'd4; reqValid = 0; step("R8");
    req(4, 0); step("R2");
    req(3, 1099); step("R5");
    reqValid = 0; step("R6");
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule